// File: doc/BRIEF.md
# Remappable external interrupt controller

The block watches a bank of external interrupt pins and routes any of them into a smaller set of interrupt slots. Each slot has its own configuration:
- a source selector that names one pin;
- a polarity bit;
- an enable bit.

The chosen pin passes through a shared two-flop synchroniser. The slot then compares it with its previous sample, and on the selected edge sets a sticky raw status bit.

Software reaches the block through a plain word-addressed register port. Writes take effect on the clock edge. Reads are combinational on the read address.

| Word address | Contents |
|---|---|
| 0 | Configuration of slots 0 to 3 |
| 1 | Configuration of slots 4 to 7 |
| 2 | Mask |
| 3 | Write-one-to-clear (write only) |
| 4 | Raw status (read only) |
| 5 | Masked status (read only) |

Slot 0 has a dedicated interrupt output. Slots 1 to 7 share a second output, which is the OR of their masked status. There is no streaming data path, so every pin is a plain level signal without handshake.

Top module: `ext_irq_router`

## Requirements
- R1: After reset, all of the following are 0: every configuration field, the mask, the raw status, every readable register, and both interrupt outputs.
- R2: Slot s is configured in byte (s mod 4) of word (s / 4). Within each byte the fields are:
  - bits [4:0] hold the source select;
  - bit 6 is the edge select;
  - bit 7 is the enable;
  - bit 5 is reserved and always reads 0.

  Word addresses 3, 6 and 7 read 0.
- R3: A select value n in 0..15 connects pin n to the slot, independent of the slot number. Select values 16..31 connect no pin, and such a slot never sets status.
- R4: With edge select 0 a slot sets raw status on a rising edge of its pin, and with edge select 1 on a falling edge. The opposite edge has no effect. A pin change made between clock edges appears in raw status at the third rising clock edge after the change, and not earlier.
- R5: A slot whose enable bit is 0 never sets raw status.
- R6: Masked status (address 5) equals raw status ANDed with the mask (address 2, bit s for slot s). The mask never changes raw status.
- R7: Raw status stays set until cleared. Writing 1 to bit s of address 3 clears slot s, and writing 0 leaves it unchanged. An edge on slot s in the same cycle as a clear of slot s leaves the bit set.
- R8: The dedicated output `irq_dedicated` equals masked status bit 0. The shared output `irq_shared` is the OR of masked status bits 1 to 7.
- R9: Two or more slots that select the same pin all set raw status on the same edge of that pin.
- R10: Writing a configuration word never creates an edge by itself. This holds when the write changes a slot's select, polarity or enable while the newly selected pin is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pins | input | 16 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_dedicated | output | 1 | Interrupt from slot 0 |
| irq_shared | output | 1 | OR of interrupts from slots 1 to 7 |

## Verification
The hardest case to reach is an edge that arrives in the same clock cycle as a clear write to its slot. The stimulus reaches it by changing a pin just after one clock edge and counting two further edges. It then places the clear write so that the clear is captured on the third edge, the same edge that registers the detected edge.

A second awkward case is a configuration write that points a slot at a pin already held high. The stimulus holds all pins high before enabling rising-edge slots, so any false edge from the reconfiguration would show up in raw status. A behavioural reference model runs alongside the directed stimulus and is compared on every clock.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int SEL_W = 5;

  typedef struct packed {
    logic             en;
    logic             falling;
    logic [SEL_W-1:0] sel;
  } slot_cfg_t;

  // byte lane layout: [7] enable, [6] falling edge, [5] reserved, [4:0] select
  function automatic slot_cfg_t byte_to_cfg(input logic [7:0] b);
    slot_cfg_t c;
    c.en      = b[7];
    c.falling = b[6];
    c.sel     = b[SEL_W-1:0];
    return c;
  endfunction

  function automatic logic [7:0] cfg_to_byte(input slot_cfg_t c);
    return {c.en, c.falling, 1'b0, c.sel};
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic [NUM_SLOTS-1:0]        raw_stat,
  output slot_cfg_t [NUM_SLOTS-1:0]   cfg_q,
  output slot_cfg_t [NUM_SLOTS-1:0]   cfg_next,
  output logic [NUM_SLOTS-1:0]        mask_q,
  output logic                        clr_wr,
  output logic [DATA_W-1:0]           rd_data
);

  localparam int LANES     = DATA_W / 8;
  localparam int CFG_WORDS = (NUM_SLOTS + LANES - 1) / LANES;
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(CFG_WORDS);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(CFG_WORDS + 1);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(CFG_WORDS + 2);
  localparam logic [ADDR_W-1:0] A_MSKD  = ADDR_W'(CFG_WORDS + 3);

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (wr_en && wr_addr == ADDR_W'(s / LANES))
        cfg_next[s] = byte_to_cfg(wr_data[(s % LANES)*8 +: 8]);
      else
        cfg_next[s] = cfg_q[s];
    end
  end

  assign clr_wr = wr_en && (wr_addr == A_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else begin
      cfg_q <= cfg_next;
      if (wr_en && wr_addr == A_MASK)
        mask_q <= wr_data[NUM_SLOTS-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_addr == ADDR_W'(s / LANES))
        rd_data[(s % LANES)*8 +: 8] = cfg_to_byte(cfg_q[s]);
    end
    if (rd_addr == A_MASK) rd_data[NUM_SLOTS-1:0] = mask_q;
    if (rd_addr == A_RAW)  rd_data[NUM_SLOTS-1:0] = raw_stat;
    if (rd_addr == A_MSKD) rd_data[NUM_SLOTS-1:0] = raw_stat & mask_q;
  end

endmodule

// File: rtl/ext_irq_slot.sv
module ext_irq_slot
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_sync,
  input  slot_cfg_t           cfg_q,
  input  slot_cfg_t           cfg_next,
  input  logic                clr,
  output logic                raw,
  output logic                edge_evt,
  output logic                sel_ok
);

  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [SEL_W:0] PIN_LIM = (SEL_W+1)'(NUM_PINS);

  function automatic logic pick(input slot_cfg_t c, input logic [NUM_PINS-1:0] p);
    if ({1'b0, c.sel} < PIN_LIM) return p[c.sel[IDX_W-1:0]];
    return 1'b0;
  endfunction

  logic prev_q, raw_q, cur, nxt, rose_s, fell_s;

  assign cur      = pick(cfg_q, pins_sync);
  assign nxt      = pick(cfg_next, pins_sync);
  assign sel_ok   = {1'b0, cfg_q.sel} < PIN_LIM;
  assign rose_s   = ~prev_q & cur;
  assign fell_s   = prev_q & ~cur;
  assign edge_evt = cfg_q.en & (cfg_q.falling ? fell_s : rose_s);
  assign raw      = raw_q;

  // previous sample follows the selection that will be in force next cycle,
  // so reconfiguration never compares against a different pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= nxt;
      raw_q  <= edge_evt | (raw_q & ~clr);
    end
  end

endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
  import ext_irq_pkg::*;
#(
  parameter  int NUM_PINS  = 16,
  parameter  int NUM_SLOTS = 8,
  parameter  int DATA_W    = 32,
  parameter  int SYNC_STG  = 2,
  localparam int LANES     = DATA_W / 8,
  localparam int CFG_WORDS = (NUM_SLOTS + LANES - 1) / LANES,
  localparam int ADDR_W    = $clog2(CFG_WORDS + 4)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] ext_pins,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq_dedicated,
  output logic                irq_shared
);

  logic [NUM_PINS-1:0]      pins_sync;
  slot_cfg_t [NUM_SLOTS-1:0] cfg_q, cfg_next;
  logic [NUM_SLOTS-1:0]     mask_q, raw_stat, edge_evt, slot_en, slot_sel_ok;
  logic [NUM_SLOTS-1:0]     masked_stat;
  logic                     clr_wr;

  ext_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pins), .q(pins_sync)
  );

  ext_irq_regs #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .raw_stat(raw_stat),
    .cfg_q(cfg_q), .cfg_next(cfg_next), .mask_q(mask_q),
    .clr_wr(clr_wr), .rd_data(rd_data)
  );

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      ext_irq_slot #(.NUM_PINS(NUM_PINS)) u_slot (
        .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync),
        .cfg_q(cfg_q[i]), .cfg_next(cfg_next[i]),
        .clr(clr_wr & wr_data[i]),
        .raw(raw_stat[i]), .edge_evt(edge_evt[i]), .sel_ok(slot_sel_ok[i])
      );
      assign slot_en[i] = cfg_q[i].en;
    end
  endgenerate

  assign masked_stat   = raw_stat & mask_q;
  assign irq_dedicated = masked_stat[0];
  assign irq_shared    = |masked_stat[NUM_SLOTS-1:1];

endmodule

// File: rtl/ext_irq_router_chk.sv
module ext_irq_router_chk #(
  parameter int NUM_SLOTS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] raw,
  input logic [NUM_SLOTS-1:0] mask,
  input logic [NUM_SLOTS-1:0] en,
  input logic [NUM_SLOTS-1:0] sel_ok,
  input logic [NUM_SLOTS-1:0] edge_evt,
  input logic                 clr_wr,
  input logic [NUM_SLOTS-1:0] clr_bits,
  input logic                 irq_ded,
  input logic                 irq_shr
);

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
      // R5
      disabled_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[i]) |-> $past(en[i]));
      // R3
      unmapped_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[i]) |-> $past(sel_ok[i]));
      // R7
      clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_bits[i] && !edge_evt[i]) |=> !raw[i]);
      // R7
      edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt[i] |=> raw[i]);
    end
  endgenerate

  // R8
  dedicated_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ded == (raw[0] & mask[0]));
  // R8
  shared_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shr == |(raw[NUM_SLOTS-1:1] & mask[NUM_SLOTS-1:1]));

endmodule

bind ext_irq_router ext_irq_router_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .raw(raw_stat), .mask(mask_q), .en(slot_en),
  .sel_ok(slot_sel_ok), .edge_evt(edge_evt), .clr_wr(clr_wr),
  .clr_bits(wr_data[NUM_SLOTS-1:0]), .irq_ded(irq_dedicated), .irq_shr(irq_shared)
);

// File: tb/sim_ext_irq_router.sv
`timescale 1ns/1ps
module sim_ext_irq_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_dedicated, irq_shared;

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_router u0 (
    .clk(clk), .rst_n(rst_n), .ext_pins(pins),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_dedicated(irq_dedicated), .irq_shared(irq_shared)
  );

  // behavioural reference model
  int        m_sel  [8];
  bit        m_fall [8];
  bit        m_en   [8];
  bit        m_prev [8];
  bit [7:0]  m_raw  = '0;
  bit [7:0]  m_mask = '0;
  bit [15:0] pq[$] = '{16'h0, 16'h0};

  function automatic bit pin_of(int sel, bit [15:0] v);
    if (sel < 16) return v[sel];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 8; s++) begin
        m_sel[s] = 0; m_fall[s] = 0; m_en[s] = 0; m_prev[s] = 0;
      end
      m_raw = '0; m_mask = '0; pq = '{16'h0, 16'h0};
    end else begin
      bit [15:0] so;
      bit [7:0]  nr;
      so = pq[0];
      for (int s = 0; s < 8; s++) begin
        bit cur, ev, clr;
        cur = pin_of(m_sel[s], so);
        ev  = m_en[s] && (m_fall[s] ? (m_prev[s] && !cur) : (!m_prev[s] && cur));
        clr = wr_en && wr_addr == 3'd3 && wr_data[s];
        nr[s] = ev || (m_raw[s] && !clr);
      end
      m_raw = nr;
      if (wr_en && wr_addr < 3'd2)
        for (int l = 0; l < 4; l++) begin
          int s;
          s = int'(wr_addr) * 4 + l;
          m_sel[s]  = int'(wr_data[l*8 +: 5]);
          m_fall[s] = wr_data[l*8 + 6];
          m_en[s]   = wr_data[l*8 + 7];
        end
      if (wr_en && wr_addr == 3'd2) m_mask = wr_data[7:0];
      for (int s = 0; s < 8; s++) m_prev[s] = pin_of(m_sel[s], so);
      void'(pq.pop_front());
      pq.push_back(pins);
    end
    started = 1;
  end

  function automatic bit [31:0] exp_rd(bit [2:0] a);
    bit [31:0] r;
    r = '0;
    case (a)
      3'd0, 3'd1:
        for (int l = 0; l < 4; l++) begin
          int s;
          s = int'(a) * 4 + l;
          r[l*8 +: 8] = {m_en[s], m_fall[s], 1'b0, 5'(m_sel[s])};
        end
      3'd2: r[7:0] = m_mask;
      3'd4: r[7:0] = m_raw;
      3'd5: r[7:0] = m_raw & m_mask;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model every clock
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R8 model irq_dedicated", {31'b0, irq_dedicated}, {31'b0, m_raw[0] & m_mask[0]});
      chk("R8 model irq_shared", {31'b0, irq_shared}, {31'b0, |(m_raw[7:1] & m_mask[7:1])});
      chk("R2 R6 model rd_data", rd_data, exp_rd(rd_addr));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    rd_addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(posedge clk); #1;
    pins = v;
    tick(4);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'h0, "R1 reset readback");
    chk("R1 reset irq_dedicated", {31'b0, irq_dedicated}, 32'h0);
    chk("R1 reset irq_shared", {31'b0, irq_shared}, 32'h0);
    rst_n = 1'b1;
    tick(2);

    // pins held high before any slot is enabled
    set_pins(16'hFFFF);
    wr(3'd0, 32'h0000_C0AA);
    wr(3'd2, 32'h0000_00FF);
    rd_chk(3'd0, 32'h0000_C08A, "R2 config layout and reserved bit");
    rd_chk(3'd3, 32'h0, "R2 clear reads zero");
    tick(4);
    rd_chk(3'd4, 32'h0, "R10 reconfiguration creates no edge");

    // opposite edge on slot 0 (rising on pin 10)
    set_pins(16'hFBFF);
    rd_chk(3'd4, 32'h0, "R4 opposite edge ignored");

    // latency of a rising edge
    rd_addr = 3'd4;
    @(posedge clk); #1;
    pins = 16'hFFFF;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R4 not set before third edge", rd_data, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 set at third edge", rd_data, 32'h1);
    chk("R8 dedicated output", {31'b0, irq_dedicated}, 32'h1);
    chk("R8 shared output idle", {31'b0, irq_shared}, 32'h0);

    wr(3'd3, 32'h0);
    rd_chk(3'd4, 32'h1, "R7 zero write has no effect");
    wr(3'd3, 32'h1);
    rd_chk(3'd4, 32'h0, "R7 clear");
    chk("R8 dedicated cleared", {31'b0, irq_dedicated}, 32'h0);

    // falling edge on slot 1 (pin 0)
    set_pins(16'hFFFE);
    rd_chk(3'd4, 32'h2, "R4 falling edge");
    chk("R8 shared output", {31'b0, irq_shared}, 32'h1);
    wr(3'd3, 32'h2);

    // two slots on pin 5
    wr(3'd0, 32'h0085_858A);
    set_pins(16'hFFDE);
    set_pins(16'hFFFE);
    rd_chk(3'd4, 32'h6, "R9 shared input sets both");

    wr(3'd2, 32'h4);
    rd_chk(3'd5, 32'h4, "R6 masked status");
    rd_chk(3'd4, 32'h6, "R6 raw unaffected by mask");
    wr(3'd2, 32'h0);
    chk("R6 shared off when masked", {31'b0, irq_shared}, 32'h0);
    wr(3'd3, 32'h6);
    wr(3'd2, 32'hFF);

    // disabled slot 3 on pin 7
    wr(3'd0, 32'h0785_858A);
    rd_chk(3'd0, 32'h0785_858A, "R2 word 0 readback");
    set_pins(16'hFF7E);
    set_pins(16'hFFFE);
    rd_chk(3'd4, 32'h0, "R5 disabled slot ignored");

    // upper word: unmapped select, pin 15, falling pin 0
    wr(3'd1, 32'hC000_8F94);
    rd_chk(3'd1, 32'hC000_8F94, "R2 word 1 readback");
    set_pins(16'h0000);
    set_pins(16'hFFFF);
    set_pins(16'h0000);
    rd_chk(3'd4, 32'hA7, "R3 selection and unmapped code");
    wr(3'd3, 32'hFF);
    rd_chk(3'd4, 32'h0, "R7 clear all");

    // edge in the same cycle as a clear write
    set_pins(16'hFFFF);
    set_pins(16'h0000);
    rd_chk(3'd4, 32'hA7, "R3 R4 status before collision");
    @(posedge clk); #1;
    pins = 16'hFFFF;
    @(posedge clk);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'hFF;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
    rd_chk(3'd4, 32'h27, "R7 edge wins over clear");

    tick(3);
    done = 1;
    summary();
    $finish;
  end

endmodule